// File: doc/BRIEF.md
# Pipelined Even-Parity Checker with Held Error Flag

This unit sits next to a registered address/command buffer and checks even parity over part of each registered data word. The parity bit from the memory controller arrives one clock after the word it covers. The unit reduces the selected bits of the word to one parity bit when the word is captured. It folds in the late parity bit and publishes two results: a partial-parity output and an active-low error flag. Once asserted, the flag is held for a minimum time.

Two strap inputs pick which bits are checked. A single unit covers the wide set of bits. Two units can also share a wide bus in a chain: the upstream unit's partial-parity output feeds the downstream unit's parity input, and only the downstream unit's error flag is meaningful. While both chip-select inputs are deasserted (high), the partial-parity output is frozen. One clock later, a registered low-power indication also freezes the error flag and its hold timer. A synchronous reset clears everything. Reset takes priority over the chip-select freeze.

Top module: `parity_guard`

## Requirements
- R1: The result is odd (partial-parity output 1, error flag low) exactly when the number of ones across the checked bits of a word plus its parity input bit is odd. Otherwise the partial-parity output is 0 and no error is flagged.
- R2: With `cfg_split`=0, regardless of `cfg_side`, the checked bits are din[1], din[2], din[4], din[5] and din[7] through din[24]. Port bit din[k-1] carries data bit k.
- R3: With `cfg_split`=1 and `cfg_side`=0 (upstream unit), the checked bits are din[1], din[2], din[4], din[5] and din[7] through din[13].
- R4: With `cfg_split`=1 and `cfg_side`=1 (downstream unit), the checked bits are din[0] through din[5] and din[7] through din[12].
- R5: Outside the downstream mode, `par_in` is sampled at the first rising edge after the edge that captures the word. `ppo` and `err_n` change at the second edge after capture.
- R6: In the downstream mode, `par_in` is sampled at the third edge after capture, and `ppo` and `err_n` change at that same edge. This is one clock after the upstream unit's `ppo` becomes valid.
- R7: An isolated odd result drives `err_n` low for exactly two clock cycles.
- R8: When odd results occur on consecutive edges, `err_n` stays low throughout. It returns high at the second edge after the last odd result.
- R9: At any edge where `cs_a_n` and `cs_b_n` are both sampled high, `ppo` keeps its value.
- R10: At an edge where both chip-selects were high at the previous edge, `err_n` and its hold timer keep their values. A hold that would have expired stays low until that condition clears.
- R11: Synchronous reset (`rst` high) sets `ppo` to 0 and `err_n` to 1 at the next edge, clears the pipeline, and overrides the chip-select freeze.
- R12: Unchecked data bits and the chip-select levels (unless both are high) have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_split | input | 1 | Strap: 0 = single wide unit, 1 = half of a chained pair |
| cfg_side | input | 1 | Strap: with cfg_split=1, 0 = upstream, 1 = downstream |
| din | input | 25 | Data word at the capture edge; bit k-1 is data bit k |
| par_in | input | 1 | Parity bit from the controller, or the upstream unit's `ppo` |
| cs_a_n | input | 1 | First chip-select, active low |
| cs_b_n | input | 1 | Second chip-select, active low |
| ppo | output | 1 | Partial-parity result |
| err_n | output | 1 | Parity error flag, active low, held |

## Verification
The risky overlap is the cycle in which an error hold runs out at the same time as the chip-select low-power freeze takes effect. Another such cycle is the one where a new result reaches `ppo` while the chip-selects gate it. The bench provokes both. It creates an isolated error, raises both chip-selects right after the error appears, and keeps them high past the point where the two-cycle hold would have ended. It then expects `ppo` to keep its odd value, expects `err_n` to stay low through the freeze, and expects both to resume one and two edges after the release.

// File: rtl/pg_pkg.sv
package pg_pkg;

    localparam int DW        = 25;
    localparam int HOLD_CYC  = 2;
    localparam int UP_TOP    = 14;
    localparam int DOWN_TOP  = 13;
    localparam int DOWN_LOW  = 6;

    typedef enum logic [1:0] {
        MODE_FULL = 2'd0,
        MODE_UP   = 2'd1,
        MODE_DOWN = 2'd2
    } chk_mode_e;

    typedef struct packed {
        logic q1;
        logic q2;
    } align_t;

    function automatic chk_mode_e mode_of(input logic split, input logic side);
        if (!split)     return MODE_FULL;
        else if (!side) return MODE_UP;
        else            return MODE_DOWN;
    endfunction

    // bit k (1-based) of the word sits at index k-1
    function automatic logic [DW-1:0] check_mask(input chk_mode_e m);
        logic [DW-1:0] r;
        r = '0;
        for (int k = 1; k <= DW; k++) begin
            if (m == MODE_DOWN)
                r[k-1] = (k <= DOWN_LOW) || (k >= 8 && k <= DOWN_TOP);
            else if (m == MODE_UP)
                r[k-1] = (k == 2) || (k == 3) || (k == 5) || (k == 6) ||
                         (k >= 8 && k <= UP_TOP);
            else
                r[k-1] = (k == 2) || (k == 3) || (k == 5) || (k == 6) || (k >= 8);
        end
        return r;
    endfunction

endpackage

// File: rtl/pg_subset_xor.sv
module pg_subset_xor
    import pg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  chk_mode_e     mode,
    input  logic [DW-1:0] din,
    output logic          q0
);
    logic [DW-1:0] msk;

    assign msk = check_mask(mode);

    // reduce the selected bits at the capture edge
    always_ff @(posedge clk) begin
        if (rst) q0 <= 1'b0;
        else     q0 <= ^(din & msk);
    end

endmodule

// File: rtl/pg_align.sv
module pg_align
    import pg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic down,
    input  logic par_in,
    input  logic q0,
    output logic res
);
    align_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.q1 <= q0 ^ (par_in & ~down);
            st.q2 <= st.q1;
        end
    end

    // downstream takes the cascaded bit two stages later
    assign res = down ? (st.q2 ^ par_in) : st.q1;

endmodule

// File: rtl/pg_err_hold.sv
module pg_err_hold
    import pg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lps,
    input  logic odd,
    output logic err_n
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            err_n <= 1'b1;
        end else if (!lps) begin
            if (odd) begin
                cnt   <= LOAD;
                err_n <= 1'b0;
            end else if (cnt != '0) begin
                cnt   <= cnt - CW'(1);
                err_n <= 1'b0;
            end else begin
                err_n <= 1'b1;
            end
        end
    end

    AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
        (!lps && odd) |=> !err_n);  // R7
    AST_LPS_FREEZE: assert property (@(posedge clk) disable iff (rst)
        lps |=> $stable(err_n));  // R10
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LOAD);  // R8

    generate
        if (HOLD_CYC >= 2) begin : g_min_hold
            AST_MIN_HOLD: assert property (@(posedge clk) disable iff (rst)
                $fell(err_n) |=> !err_n);  // R7
        end
    endgenerate

endmodule

// File: rtl/parity_guard.sv
module parity_guard
    import pg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_split,
    input  logic          cfg_side,
    input  logic [DW-1:0] din,
    input  logic          par_in,
    input  logic          cs_a_n,
    input  logic          cs_b_n,
    output logic          ppo,
    output logic          err_n
);
    chk_mode_e mode;
    logic      q0;
    logic      res;
    logic      gate;
    logic      lps_q;

    assign mode = mode_of(cfg_split, cfg_side);
    assign gate = cs_a_n & cs_b_n;

    pg_subset_xor u_xor (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .din  (din),
        .q0   (q0)
    );

    pg_align u_align (
        .clk    (clk),
        .rst    (rst),
        .down   (mode == MODE_DOWN),
        .par_in (par_in),
        .q0     (q0),
        .res    (res)
    );

    pg_err_hold u_hold (
        .clk   (clk),
        .rst   (rst),
        .lps   (lps_q),
        .odd   (res),
        .err_n (err_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lps_q <= 1'b0;
            ppo   <= 1'b0;
        end else begin
            lps_q <= gate;
            if (!gate) ppo <= res;
        end
    end

    AST_PPO_GATE: assert property (@(posedge clk) disable iff (rst)
        gate |=> $stable(ppo));  // R9
    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (!ppo && err_n));  // R11

endmodule

// File: tb/sim_parity_guard.sv
`timescale 1ns/1ps
module sim_parity_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        split = 1'b0;
    logic        side = 1'b0;
    logic [24:0] din = '0;
    logic        par = 1'b0;
    logic        csa = 1'b0;
    logic        csb = 1'b0;
    logic        ppo;
    logic        err_n;
    int          checks = 0;
    int          errs = 0;

    always #4 clk = ~clk;

    parity_guard u0 (
        .clk(clk), .rst(rst), .cfg_split(split), .cfg_side(side),
        .din(din), .par_in(par), .cs_a_n(csa), .cs_b_n(csb),
        .ppo(ppo), .err_n(err_n)
    );

    // {split, side, parity, word}; entries 4 and 6 set unchecked bits (R12)
    localparam logic [27:0] VEC [12] = '{
        {1'b0, 1'b0, 1'b0, 25'h0000000},
        {1'b0, 1'b0, 1'b1, 25'h0000000},
        {1'b0, 1'b0, 1'b0, 25'h0000006},
        {1'b0, 1'b0, 1'b0, 25'h1000000},
        {1'b0, 1'b0, 1'b0, 25'h0000049},
        {1'b0, 1'b1, 1'b1, 25'h0000080},
        {1'b1, 1'b0, 1'b0, 25'h0006000},
        {1'b1, 1'b0, 1'b1, 25'h1FFFFFF},
        {1'b1, 1'b1, 1'b0, 25'h0000001},
        {1'b1, 1'b1, 1'b1, 25'h1FFFFFF},
        {1'b1, 1'b1, 1'b0, 25'h0002040},
        {1'b0, 1'b0, 1'b1, 25'h0AAAAAA}
    };

    function automatic logic in_set(input logic sp, input logic sd, input int k);
        if (sp && sd) return (k >= 1 && k <= 6) || (k >= 8 && k <= 13);
        if (sp)       return k == 2 || k == 3 || k == 5 || k == 6 || (k >= 8 && k <= 14);
        return k == 2 || k == 3 || k == 5 || k == 6 || (k >= 8 && k <= 25);
    endfunction

    function automatic logic model_odd(input logic sp, input logic sd,
                                       input logic p, input logic [24:0] d);
        int n = 0;
        for (int k = 1; k <= 25; k++)
            if (in_set(sp, sd, k) && d[k-1]) n++;
        return ((n + int'(p)) % 2) == 1;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [27:0] v, input logic one_cs);
        logic sp, sd, p, e;
        logic [24:0] d;
        string tg;
        sp = v[27]; sd = v[26]; p = v[25]; d = v[24:0];
        split = sp; side = sd; din = '0; par = 1'b0;
        csa = one_cs; csb = 1'b0;
        repeat (4) tick();
        e  = model_odd(sp, sd, p, d);
        tg = (sp && sd) ? "R1 R4 R6" : (sp ? "R1 R3 R5" : "R1 R2 R5 R12");
        din = d;
        tick();
        din = '0;
        if (sp && sd) begin
            tick(); tick();
            par = p;
            tick();
        end else begin
            par = p;
            tick();
            par = 1'b0;
            tick();
        end
        par = 1'b0;
        chk({tg, " ppo"}, ppo, e);
        chk({tg, " err_n"}, err_n, ~e);
        tick();
        chk("R7 hold second cycle", err_n, ~e);
        tick();
        chk("R7 release", err_n, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        chk("R11 reset ppo", ppo, 1'b0);
        chk("R11 reset err_n", err_n, 1'b1);
        rst = 1'b0;

        for (int i = 0; i < 12; i++) run_vec(VEC[i], i[0]);
        csa = 1'b0;

        // R8: three odd words in a row, full mode
        split = 1'b0; side = 1'b0; din = '0; par = 1'b0;
        repeat (4) tick();
        din = 25'h2;
        tick(); tick(); tick();
        din = '0;
        chk("R8 first odd", err_n, 1'b0);
        tick(); tick();
        chk("R8 last odd", err_n, 1'b0);
        tick();
        chk("R8 hold after last", err_n, 1'b0);
        tick();
        chk("R8 release", err_n, 1'b1);

        // R9/R10: freeze lands as the hold would expire
        repeat (3) tick();
        din = 25'h2;
        tick();
        din = '0;
        tick(); tick();
        chk("R9 setup ppo", ppo, 1'b1);
        csa = 1'b1; csb = 1'b1;
        tick();
        chk("R9 ppo held", ppo, 1'b1);
        chk("R10 err_n before freeze", err_n, 1'b0);
        tick();
        chk("R10 err_n frozen", err_n, 1'b0);
        tick();
        chk("R10 err_n still frozen", err_n, 1'b0);
        csa = 1'b0; csb = 1'b0;
        tick();
        chk("R9 ppo resumes", ppo, 1'b0);
        chk("R10 err_n frozen one more", err_n, 1'b0);
        tick();
        chk("R10 err_n resumes", err_n, 1'b1);

        // R11: reset beats the chip-select freeze
        repeat (3) tick();
        din = 25'h2;
        tick();
        din = '0;
        tick(); tick();
        chk("R11 setup err_n", err_n, 1'b0);
        csa = 1'b1; csb = 1'b1; rst = 1'b1;
        tick();
        chk("R11 ppo cleared", ppo, 1'b0);
        chk("R11 err_n cleared", err_n, 1'b1);
        rst = 1'b0; csa = 1'b0; csb = 1'b0;
        tick();

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule